// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reload

This block is a watchdog that asks for a system reset when firmware stops servicing it. A free-running slow tick (nominally 32 kHz) drives a prescaler of `PRESC_W` bits. Each time the prescaler wraps, a down-counter of `CNT_W` bits takes one step. With the default widths of 9 and 8 bits, one step is 512 ticks, or 16 ms. A reload value N of 1 or more gives an interval of exactly N prescaler periods. The range runs from one period up to 255 periods, about 4.08 s. The watchdog counts on the slow tick alone, so it keeps running while the processor sleeps.

Firmware reaches the block through a simple synchronous port with two registers. The control register holds the enable flag (bit 1) and the reload-arm flag (bit 0). The count register loads the down-counter. A count write takes effect only while the arm flag is set, and each accepted write clears the arm flag, so every reload needs a fresh arming write. An armed write of zero is the only way to switch the watchdog off. Every accepted load restarts the prescaler from zero.

The control sequencing is a three-state machine:
- `WD_OFF`: disabled, with prescaler and counter frozen.
- `WD_RUN`: counting.
- `WD_FIRE`: one cycle that raises the reset request.

The transitions are:
- `start`: `WD_OFF`→`WD_RUN`, on a control write with bit 1 set.
- `stop`: `WD_RUN`→`WD_OFF`, on an armed write of zero.
- `expire`: `WD_RUN`→`WD_FIRE`, on a prescaler wrap with the count at 1 or 0, and no accepted load in the same cycle.
- `recover`: `WD_FIRE`→`WD_OFF`, unconditionally.

All other cases hold the current state.

Top module: `wdog_guarded`

## Requirements
- R1: After `rst_n` is released, the control register reads 0, the count register reads 0, and `sys_rst_req` is low.
- R2: A control write with bit 1 set turns on the enable flag. While enabled, a control write with bit 1 clear leaves the enable flag set.
- R3: A count-register write made while the arm flag (control bit 0) is clear leaves the count unchanged.
- R4: An armed count write loads the written value into the counter and clears the arm flag on the same clock edge. The control register then reads 2 if the watchdog is enabled and 0 if it is disabled.
- R5: An armed count write of zero clears both the enable flag and the arm flag. No reset request follows, however many ticks arrive afterwards.
- R6: While enabled, the count readback drops by one every 2^PRESC_W ticks. After a load of N (N≥1), `sys_rst_req` rises on exactly the N·2^PRESC_W-th tick after the load and not before.
- R7: Every accepted load restarts the prescaler, so a reload made partway through a period yields a full N·2^PRESC_W-tick interval.
- R8: `sys_rst_req` is high for exactly one clock cycle. On the next cycle the control register and the count register both read 0.
- R9: While disabled, ticks change neither the count nor the prescaler.
- R10: If the watchdog is enabled with the count at 0, the reset request comes after one prescaler period (2^PRESC_W ticks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse from the slow free-running time base |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control, 1 = count |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 1 | Read target: 0 = control, 1 = count |
| rd_data | output | CNT_W | Read data. Control reads {0, enable, arm}; count reads the current count. |
| sys_rst_req | output | 1 | Single-cycle reset request on expiry |

## Verification
The bound checker watches several rules on every cycle:
- the reset request stays one cycle wide, and the block is back in its power-up state one cycle later;
- a locked count write leaves the counter alone;
- an armed load stores the written data, drops the arm flag and zeroes the prescaler;
- the enable flag only ever falls through a zero load or an expiry;
- the counter and prescaler stay frozen while the watchdog is off.

Exact interval lengths can only be shown by the bench's scenarios. These cover a sweep over every reload value of a 4-bit counter with a 4-tick period, a reload made partway through a period, enabling with an empty count, and a long run after a zero load. All of them count ticks against arithmetic expectations.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    localparam logic SEL_CTRL  = 1'b0;
    localparam logic SEL_COUNT = 1'b1;

    localparam int CTRL_ARM_BIT = 0;
    localparam int CTRL_EN_BIT  = 1;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRESC_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic               tick,
    output logic               wrap,
    output logic [PRESC_W-1:0] presc_q
);
    localparam logic [PRESC_W-1:0] PRESC_MAX = {PRESC_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            presc_q <= '0;
        end else if (run && tick) begin
            presc_q <= presc_q + 1'b1;
        end
    end

    always_comb begin
        wrap = run && tick && !clr && (presc_q == PRESC_MAX);
    end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q,
    output logic             last
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        last = (cnt_q <= CNT_ONE);
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_ctrl,
    input  logic      ctrl_en_bit,
    input  logic      ctrl_arm_bit,
    input  logic      wr_count,
    input  logic      count_is_zero,
    input  logic      expire,
    output wd_state_e state_q,
    output logic      arm_q,
    output logic      load,
    output logic      running,
    output logic      fire
);
    wd_state_e state_d;
    logic      arm_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            arm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            arm_q   <= arm_d;
        end
    end

    // next state and arm flag
    always_comb begin
        state_d = state_q;
        arm_d   = arm_q;
        unique case (state_q)
            WD_OFF: begin
                if (wr_ctrl && ctrl_en_bit) state_d = WD_RUN;             // start
            end
            WD_RUN: begin
                if (load && count_is_zero) state_d = WD_OFF;              // stop
                else if (!load && expire)  state_d = WD_FIRE;             // expire
            end
            WD_FIRE: begin
                state_d = WD_OFF;                                         // recover
            end
            default: state_d = WD_OFF;
        endcase
        if (state_q == WD_FIRE) arm_d = 1'b0;
        else if (load)          arm_d = 1'b0;
        else if (wr_ctrl)       arm_d = ctrl_arm_bit;
    end

    // outputs
    always_comb begin
        load    = wr_count && arm_q && (state_q != WD_FIRE);
        running = (state_q == WD_RUN);
        fire    = (state_q == WD_FIRE);
    end
endmodule

// File: rtl/wdog_guarded.sv
module wdog_guarded
    import wdog_pkg::*;
#(
    parameter int PRESC_W = 9,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             sys_rst_req
);
    wd_state_e          state_q;
    logic               arm_q;
    logic               load;
    logic               running;
    logic               fire;
    logic               wrap;
    logic               last;
    logic               expire;
    logic               wr_ctrl;
    logic               wr_count;
    logic               count_is_zero;
    logic [PRESC_W-1:0] presc_q;
    logic [CNT_W-1:0]   cnt_q;

    always_comb begin
        wr_ctrl       = wr_en && (wr_sel == SEL_CTRL);
        wr_count      = wr_en && (wr_sel == SEL_COUNT);
        count_is_zero = (wr_data == '0);
        expire        = wrap && last;
    end

    wdog_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_ctrl       (wr_ctrl),
        .ctrl_en_bit   (wr_data[CTRL_EN_BIT]),
        .ctrl_arm_bit  (wr_data[CTRL_ARM_BIT]),
        .wr_count      (wr_count),
        .count_is_zero (count_is_zero),
        .expire        (expire),
        .state_q       (state_q),
        .arm_q         (arm_q),
        .load          (load),
        .running       (running),
        .fire          (fire)
    );

    wdog_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load || fire),
        .run     (running),
        .tick    (tick),
        .wrap    (wrap),
        .presc_q (presc_q)
    );

    wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fire),
        .load     (load),
        .load_val (wr_data),
        .step     (wrap),
        .cnt_q    (cnt_q),
        .last     (last)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_COUNT) begin
            rd_data = cnt_q;
        end else begin
            rd_data[CTRL_EN_BIT]  = running;
            rd_data[CTRL_ARM_BIT] = arm_q;
        end
        sys_rst_req = fire;
    end
endmodule

// File: rtl/wdog_guarded_chk.sv
module wdog_guarded_chk #(
    parameter int PRESC_W = 9,
    parameter int CNT_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               wr_en,
    input logic               wr_sel,
    input logic [CNT_W-1:0]   wr_data,
    input logic               sys_rst_req,
    input logic               en,
    input logic               arm,
    input logic [CNT_W-1:0]   cnt,
    input logic [PRESC_W-1:0] presc
);
    logic armed_load;
    assign armed_load = wr_en && wr_sel && arm && !sys_rst_req;

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    assert_fire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> (!en && !arm && cnt == '0 && presc == '0));

    assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !arm && !tick && !sys_rst_req) |=> $stable(cnt));

    assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_load |=> (cnt == $past(wr_data) && !arm));

    assert_zero_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_load && wr_data == '0) |=> !en);

    assert_presc_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_load |=> (presc == '0));

    assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sys_rst_req && !(wr_en && wr_sel)) |=> ($stable(cnt) && $stable(presc)));

    assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sys_rst_req && !(armed_load && wr_data == '0)) |=> (en || sys_rst_req));
endmodule

bind wdog_guarded wdog_guarded_chk #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .sys_rst_req (sys_rst_req),
    .en          (running),
    .arm         (arm_q),
    .cnt         (cnt_q),
    .presc       (presc_q)
);

// File: tb/tb_wdog_guarded.sv
module tb_wdog_guarded;
    localparam int PW   = 2;
    localparam int CW   = 4;
    localparam int PER  = 1 << PW;
    localparam int NMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic          rd_sel = 1'b0;
    logic [CW-1:0] rd_data;
    logic          sys_rst_req;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    wdog_guarded #(.PRESC_W(PW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .sys_rst_req(sys_rst_req)
    );

    always @(posedge clk) begin
        if (rst_n && sys_rst_req) pulses <= pulses + 1;
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired: actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = CW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output int val);
        rd_sel = sel;
        #1;
        val = int'(rd_data);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        int v;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl", v, 0);
        rd(1'b1, v); chk("R1 count", v, 0);
        chk("R1 pulse", int'(sys_rst_req), 0);

        // R3 locked write while disabled
        wr(1'b1, 7);
        rd(1'b1, v); chk("R3 locked write", v, 0);

        // R2 enable and sticky enable
        wr(1'b0, 2);
        rd(1'b0, v); chk("R2 enable", v, 2);
        wr(1'b0, 0);
        rd(1'b0, v); chk("R2 sticky enable", v, 2);
        wr(1'b1, 9);
        rd(1'b1, v); chk("R3 locked write enabled", v, 0);

        // R10 enabled with count 0 fires after one period
        p0 = pulses;
        ticks(PER - 1);
        chk("R10 no early pulse", int'(sys_rst_req), 0);
        ticks(1);
        chk("R10 pulse after one period", int'(sys_rst_req), 1);
        @(negedge clk);
        chk("R8 single cycle", pulses - p0, 1);
        rd(1'b0, v); chk("R8 ctrl cleared", v, 0);

        // R4 load while disabled, R9 hold while disabled
        wr(1'b0, 1);
        rd(1'b0, v); chk("R4 arm set", v, 1);
        wr(1'b1, 5);
        rd(1'b1, v); chk("R4 loaded", v, 5);
        rd(1'b0, v); chk("R4 arm cleared disabled", v, 0);
        ticks(5 * PER);
        rd(1'b1, v); chk("R9 hold while disabled", v, 5);
        chk("R9 no pulse", pulses - p0, 1);

        // R6 sweep over every reload value
        for (int n = 1; n <= NMAX; n++) begin
            wr(1'b0, 3);
            wr(1'b1, n);
            rd(1'b1, v); chk("R4 sweep load", v, n);
            rd(1'b0, v); chk("R4 arm cleared enabled", v, 2);
            for (int j = 1; j < n; j++) begin
                ticks(PER);
                rd(1'b1, v); chk("R6 decrement", v, n - j);
            end
            p0 = pulses;
            ticks(PER - 1);
            chk("R6 no early pulse", int'(sys_rst_req), 0);
            ticks(1);
            chk("R6 pulse at interval", int'(sys_rst_req), 1);
            @(negedge clk);
            chk("R8 single cycle", pulses - p0, 1);
            rd(1'b0, v); chk("R8 ctrl cleared", v, 0);
            rd(1'b1, v); chk("R8 count cleared", v, 0);
        end

        // R7 reload midway through a period restarts the prescaler
        wr(1'b0, 3);
        wr(1'b1, 3);
        ticks(PER + 2);
        rd(1'b1, v); chk("R7 partial progress", v, 2);
        wr(1'b0, 1);
        wr(1'b1, 3);
        p0 = pulses;
        ticks(3 * PER - 1);
        chk("R7 no early pulse", int'(sys_rst_req), 0);
        rd(1'b1, v); chk("R7 count before expiry", v, 1);
        ticks(1);
        chk("R7 full interval", int'(sys_rst_req), 1);
        @(negedge clk);

        // R5 zero load disables
        wr(1'b0, 3);
        wr(1'b1, 6);
        ticks(5);
        wr(1'b0, 1);
        wr(1'b1, 0);
        rd(1'b0, v); chk("R5 flags cleared", v, 0);
        p0 = pulses;
        ticks(NMAX * PER + 8);
        chk("R5 no reset request", pulses - p0, 0);
        rd(1'b1, v); chk("R5 count zero", v, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule